// File: doc/BRIEF.md
# Data Link Interrupt Status Unit

This block gathers eight events from the receive and transmit sides of a serial data link and holds each one in a bit of an 8-bit status register. A processor reads that register and uses it to find out why the interrupt fired. Some events come from per-cycle strobe inputs: codeword arrival, message arrival, message sent, transmit underrun, processor write attempt and receiver write attempt. The others come from comparing the receive and transmit FIFO fill levels with static threshold inputs. The FIFOs, the framing logic and the codeword decoder sit outside the block and are seen only through these inputs.

Each bit latches on the rising edge of its source condition. It holds until the processor reads the status register, and that read clears every bit. The processor can also read and write an 8-bit enable register. The single interrupt output is registered and is high when any status bit is set together with its enable bit. The receive-full bit depends on the mode. In framed (HDLC) mode it marks an overrun. In unformatted packing mode it marks that the fill level has reached a programmable limit.

Top module: `dl_irq_status`

## Requirements
- R1: The status register has these fields: bit 7 codeword received, bit 6 receive full, bit 5 receive near full, bit 4 receive message, bit 3 transmit underrun error, bit 2 transmit overflow, bit 1 transmit near empty, bit 0 message transmitted. It is read with bus_rd=1 and bus_addr=0, and its value appears on bus_rdata in the same cycle.
- R2: A status bit is set only when its source condition goes from low to high. A condition that stays high does not set the bit again after the bit has been cleared.
- R3: A read of the status register clears all bits on the next clock edge. A source that rises in the same cycle as the read leaves its bit set.
- R4: Once a status bit is set, it stays set until the status register is read.
- R5: irq is registered. One cycle after (status AND enable) is nonzero, irq is 1, and one cycle after it is zero, irq is 0.
- R6: When mode=0 (HDLC), bit 6 is set when rx_wr is pulsed while rx_level equals DEPTH. rx_level reaching rx_fill_lim has no effect on bit 6 in this mode.
- R7: When mode=1 (unformatted), bit 6 is set when rx_level rises to rx_fill_lim or above.
- R8: Bit 5 is set when rx_level rises to rx_near_thr or above.
- R9: Bit 1 is set when tx_level falls below tx_near_thr.
- R10: Bit 2 is set when tx_wr is pulsed while tx_level equals DEPTH. A write while the FIFO is not full has no effect.
- R11: Pulses on rx_cw, rx_msg, tx_udr and tx_msg set bits 7, 4, 3 and 0 respectively.
- R12: The enable register is written with bus_wr=1 and bus_addr=1 and read back on bus_rdata with bus_addr=1. It resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = HDLC, 1 = unformatted packing |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_near_thr | input | LVL_W | Receive near-full threshold |
| rx_fill_lim | input | LVL_W | Receive fill limit for unformatted mode |
| tx_near_thr | input | LVL_W | Transmit near-empty threshold |
| rx_cw | input | 1 | Codeword received strobe |
| rx_msg | input | 1 | Message received strobe |
| rx_wr | input | 1 | Receiver write attempt strobe |
| tx_wr | input | 1 | Processor transmit write attempt strobe |
| tx_udr | input | 1 | Transmit underrun strobe |
| tx_msg | input | 1 | Message transmitted strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = status, 1 = enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The three threshold comparisons are swept over every threshold from 1 to DEPTH. For each threshold the fill level is walked one step at a time and the status is read and cleared after every step. This shows that each bit latches at the exact crossing level and is not set again while the level stays past it. The receive-full bit is tried in both modes with write attempts at every level, which tells an overrun apart from reaching the fill limit. Each strobe source is tried on its own, a held level is used to separate edge capture from level capture, and a source rise that lands in the same cycle as a read checks that the event survives the read. Enable masking and the one-cycle interrupt latency are checked cycle by cycle around a set and a clear.

// File: rtl/dl_irq_pkg.sv
package dl_irq_pkg;
  localparam int NEV      = 8;
  localparam int B_CW     = 7;
  localparam int B_RXFULL = 6;
  localparam int B_RXNEAR = 5;
  localparam int B_RXMSG  = 4;
  localparam int B_TXERR  = 3;
  localparam int B_TXOVF  = 2;
  localparam int B_TXNEAR = 1;
  localparam int B_TXMSG  = 0;

  typedef enum logic {
    MODE_HDLC  = 1'b0,
    MODE_UNFMT = 1'b1
  } dl_mode_e;

  typedef enum logic {
    ADDR_STAT = 1'b0,
    ADDR_EN   = 1'b1
  } dl_addr_e;
endpackage

// File: rtl/dl_irq_cond.sv
module dl_irq_cond
  import dl_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             mode,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_near_thr,
  input  logic [LVL_W-1:0] rx_fill_lim,
  input  logic [LVL_W-1:0] tx_near_thr,
  input  logic             rx_cw,
  input  logic             rx_msg,
  input  logic             rx_wr,
  input  logic             tx_wr,
  input  logic             tx_udr,
  input  logic             tx_msg,
  output logic [NEV-1:0]   cond
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  dl_mode_e mode_e;
  logic     rx_is_full;
  logic     tx_is_full;

  always_comb begin
    mode_e     = dl_mode_e'(mode);
    rx_is_full = (rx_level == FULL_LVL);
    tx_is_full = (tx_level == FULL_LVL);
    cond           = '0;
    cond[B_CW]     = rx_cw;
    cond[B_RXFULL] = (mode_e == MODE_UNFMT) ? (rx_level >= rx_fill_lim)
                                            : (rx_wr && rx_is_full);
    cond[B_RXNEAR] = (rx_level >= rx_near_thr);
    cond[B_RXMSG]  = rx_msg;
    cond[B_TXERR]  = tx_udr;
    cond[B_TXOVF]  = tx_wr && tx_is_full;
    cond[B_TXNEAR] = (tx_level < tx_near_thr);
    cond[B_TXMSG]  = tx_msg;
  end
endmodule

// File: rtl/dl_irq_latch.sv
module dl_irq_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         clr,
  output logic [N-1:0] prev_q,
  output logic [N-1:0] stat_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise;
    logic stat_d;

    always_comb begin
      rise   = cond[i] & ~prev_q[i];
      stat_d = (stat_q[i] & ~clr) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        stat_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= cond[i];
        stat_q[i] <= stat_d;
      end
    end
  end
endmodule

// File: rtl/dl_irq_status.sv
module dl_irq_status
  import dl_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_near_thr,
  input  logic [LVL_W-1:0] rx_fill_lim,
  input  logic [LVL_W-1:0] tx_near_thr,
  input  logic             rx_cw,
  input  logic             rx_msg,
  input  logic             rx_wr,
  input  logic             tx_wr,
  input  logic             tx_udr,
  input  logic             tx_msg,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [NEV-1:0]   bus_wdata,
  output logic [NEV-1:0]   bus_rdata,
  output logic             irq
);
  logic [NEV-1:0] src_cond;
  logic [NEV-1:0] src_prev;
  logic [NEV-1:0] stat_q;
  logic [NEV-1:0] en_q;
  logic [NEV-1:0] en_d;
  logic           rd_clr;
  logic           en_we;
  logic           irq_d;
  logic           irq_q;
  dl_addr_e       addr_e;

  dl_irq_cond #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cond (
    .mode(mode), .rx_level(rx_level), .tx_level(tx_level),
    .rx_near_thr(rx_near_thr), .rx_fill_lim(rx_fill_lim),
    .tx_near_thr(tx_near_thr), .rx_cw(rx_cw), .rx_msg(rx_msg),
    .rx_wr(rx_wr), .tx_wr(tx_wr), .tx_udr(tx_udr), .tx_msg(tx_msg),
    .cond(src_cond)
  );

  dl_irq_latch #(.N(NEV)) u_latch (
    .clk(clk), .rst_n(rst_n), .cond(src_cond), .clr(rd_clr),
    .prev_q(src_prev), .stat_q(stat_q)
  );

  always_comb begin
    addr_e    = dl_addr_e'(bus_addr);
    rd_clr    = bus_rd && (addr_e == ADDR_STAT);
    en_we     = bus_wr && (addr_e == ADDR_EN);
    en_d      = en_we ? bus_wdata : en_q;
    irq_d     = |(stat_q & en_q);
    bus_rdata = (addr_e == ADDR_EN) ? en_q : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/dl_irq_status_chk.sv
module dl_irq_status_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic [N-1:0] cond,
  input logic [N-1:0] prev,
  input logic [N-1:0] status,
  input logic [N-1:0] en,
  input logic         irq
);
  // R4: set bits persist while no status read happens
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status)));

  // R2: a newly set bit must come from a low-to-high source change
  p_newset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status & ~$past(status)) & ~$past(cond & ~prev)) == '0));

  // R3: after a read only bits whose source just rose remain
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((status & ~$past(cond & ~prev)) == '0));

  // R5: interrupt follows masked status one cycle later
  p_irq_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & en)) |=> irq);

  p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & en)) |=> !irq);
endmodule

bind dl_irq_status dl_irq_status_chk #(.N(dl_irq_pkg::NEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(rd_clr), .cond(src_cond),
  .prev(src_prev), .status(stat_q), .en(en_q), .irq(irq)
);

// File: tb/sim_dl_irq_status.sv
module sim_dl_irq_status;
  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode;
  logic [LW-1:0] rx_level, tx_level, rx_near_thr, rx_fill_lim, tx_near_thr;
  logic          rx_cw, rx_msg, rx_wr, tx_wr, tx_udr, tx_msg;
  logic          bus_rd, bus_wr, bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  dl_irq_status #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_level(rx_level),
    .tx_level(tx_level), .rx_near_thr(rx_near_thr), .rx_fill_lim(rx_fill_lim),
    .tx_near_thr(tx_near_thr), .rx_cw(rx_cw), .rx_msg(rx_msg), .rx_wr(rx_wr),
    .tx_wr(tx_wr), .tx_udr(tx_udr), .tx_msg(tx_msg), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // sample status now, then clear it with a one-cycle read
  task automatic rd_clr(output logic [7:0] val);
    bus_addr = 1'b0;
    val = bus_rdata;
    bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic pulse_cw();  rx_cw = 1'b1;  tick(); rx_cw = 1'b0;  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0;
    rx_level = '0; tx_level = LW'(DEPTH);
    rx_near_thr = LW'(DEPTH); rx_fill_lim = LW'(DEPTH); tx_near_thr = '0;
    rx_cw = 0; rx_msg = 0; rx_wr = 0; tx_wr = 0; tx_udr = 0; tx_msg = 0;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    chk("R1 reset status", bus_rdata, 0);
    chk("R5 reset irq", irq, 0);
    bus_addr = 1'b1;
    chk("R12 reset enable", bus_rdata, 0);
    bus_addr = 1'b0;

    // R8 sweep receive near-full threshold
    for (int t = 1; t <= DEPTH; t++) begin
      rx_level = '0; rx_near_thr = LW'(t); tick(); rd_clr(v);
      for (int l = 0; l <= DEPTH; l++) begin
        rx_level = LW'(l); tick(); rd_clr(v);
        chk($sformatf("R8 near thr %0d lvl %0d", t, l), v[5], (l == t) ? 1 : 0);
      end
    end
    rx_level = '0; rx_near_thr = LW'(DEPTH); tick(); rd_clr(v);

    // R7 sweep fill limit in unformatted mode
    mode = 1'b1;
    for (int t = 1; t <= DEPTH; t++) begin
      rx_level = '0; rx_fill_lim = LW'(t); tick(); rd_clr(v);
      for (int l = 0; l <= DEPTH; l++) begin
        rx_level = LW'(l); tick(); rd_clr(v);
        chk($sformatf("R7 lim %0d lvl %0d", t, l), v[6], (l == t) ? 1 : 0);
      end
    end
    rx_level = '0; rx_fill_lim = LW'(DEPTH); mode = 1'b0; tick(); rd_clr(v);

    // R9 sweep transmit near-empty threshold
    for (int t = 1; t <= DEPTH; t++) begin
      tx_level = LW'(DEPTH); tx_near_thr = LW'(t); tick(); rd_clr(v);
      for (int l = DEPTH; l >= 0; l--) begin
        tx_level = LW'(l); tick(); rd_clr(v);
        chk($sformatf("R9 thr %0d lvl %0d", t, l), v[1], (l == t - 1) ? 1 : 0);
      end
    end
    tx_level = LW'(DEPTH); tx_near_thr = '0; tick(); rd_clr(v);

    // R6 HDLC overrun: only write attempts at full level count
    for (int l = 0; l <= DEPTH; l++) begin
      rx_level = LW'(l); tick(); rd_clr(v);
      chk($sformatf("R6 no write lvl %0d", l), bus_rdata[6], 0);
      rx_wr = 1'b1; tick(); rx_wr = 1'b0;
      rd_clr(v);
      chk($sformatf("R6 write lvl %0d", l), v[6], (l == DEPTH) ? 1 : 0);
    end
    rx_level = '0; tick(); rd_clr(v);

    // R10 transmit overflow
    for (int l = DEPTH - 1; l <= DEPTH; l++) begin
      tx_level = LW'(l); tick(); rd_clr(v);
      tx_wr = 1'b1; tick(); tx_wr = 1'b0;
      rd_clr(v);
      chk($sformatf("R10 write lvl %0d", l), v[2], (l == DEPTH) ? 1 : 0);
    end
    tx_level = LW'(DEPTH); tick(); rd_clr(v);

    // R11 / R1 strobe sources land in their own bit only
    pulse_cw(); rd_clr(v); chk("R11 cw bit7", v, 8'h80);
    rx_msg = 1; tick(); rx_msg = 0; rd_clr(v); chk("R11 rxmsg bit4", v, 8'h10);
    tx_udr = 1; tick(); tx_udr = 0; rd_clr(v); chk("R11 udr bit3", v, 8'h08);
    tx_msg = 1; tick(); tx_msg = 0; rd_clr(v); chk("R11 txmsg bit0", v, 8'h01);

    // R4 hold until read, R3 read clears
    pulse_cw(); repeat (5) tick();
    chk("R4 held", bus_rdata, 8'h80);
    rd_clr(v);
    chk("R3 cleared", bus_rdata, 0);

    // R2 held level does not re-set after clear
    rx_msg = 1; tick();
    chk("R2 first edge", bus_rdata, 8'h10);
    rd_clr(v); tick();
    chk("R2 level held no reset", bus_rdata, 0);
    rx_msg = 0; tick();

    // R3 rise in same cycle as read is kept
    pulse_cw(); tick();
    bus_rd = 1'b1; rx_msg = 1'b1; tick();
    bus_rd = 1'b0; rx_msg = 1'b0;
    chk("R3 concurrent rise kept", bus_rdata, 8'h10);
    rd_clr(v);

    // R12 enable write and readback
    bus_wr = 1; bus_addr = 1; bus_wdata = 8'h10; tick();
    bus_wr = 0; chk("R12 enable readback", bus_rdata, 8'h10);
    bus_addr = 0;

    // R5 masked bit does not interrupt
    pulse_cw(); tick();
    chk("R5 masked no irq", irq, 0);
    rd_clr(v); tick();

    // R5 enabled bit: irq one cycle after status
    rx_msg = 1; tick(); rx_msg = 0;
    chk("R5 status set", bus_rdata, 8'h10);
    chk("R5 irq not yet", irq, 0);
    tick();
    chk("R5 irq asserted", irq, 1);
    rd_clr(v);
    chk("R5 irq still high after clear edge", irq, 1);
    tick();
    chk("R5 irq dropped", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule